// File: doc/BRIEF.md
# System Error Signaling Collector

This block collects fault events from the safety checkers of a device, such as memory parity checkers, ECC correction logic and the lockstep core comparator. It records each event in a sticky status bit. Software programs a separate response for each source. The response can raise a maskable interrupt, a non-maskable interrupt, an external fault pin, or any mix of the three. This lets a severe fault stop the processor at once, while a mild one only raises an interrupt.

The fault pin is active low. It tells an observer outside the device that the device is in a faulty state. Once the pin goes low, it stays low for at least a programmable number of cycles. Software can release it only in this order: it first clears every pin-routed status bit, then it writes a key value to the release register.

Software reaches the block through a simple write port and a combinational read port. Both share one address.

Top module: `fault_aggregator`

## Requirements
- R1: After reset:
  - every status bit and every enable bit is 0;
  - the hold register reads 4;
  - `irq_o` and `nmi_o` are low;
  - `err_n_o` is high.
- R2: A source input that is high at a clock edge sets its status bit (address 0). The bit stays set until software clears it.
- R3: Writing to address 0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When an event arrives in the same cycle as a clear of its own status bit, the bit stays set.
- R5: `irq_o` is a level output. It is high exactly when some status bit is set and its interrupt enable bit (address 1) is also set. It follows changes to both the status and the enable.
- R6: `nmi_o` is a level output. It is high exactly when some status bit is set and its non-maskable enable bit (address 2) is also set.
- R7: An event whose pin enable bit (address 3) is set drives `err_n_o` low from the next clock edge. Such an event also reloads the hold counter from the hold register (address 4). Events whose pin enable bit is clear leave the pin unchanged.
- R8: A key write to address 5 is ignored until the hold counter has counted down to zero. The counter falls by one per cycle, so the earliest release comes hold+1 edges after the pin went low.
- R9: A key write is ignored while any status bit that has its pin enable set is still set. Reading address 5 returns the pin state in bit 0, where 1 means the pin is active (low).
- R10: Writing address 5 with any value other than the key 16'hA5C3 leaves the pin unchanged.
- R11: Addresses 1 to 4 read back the last value written to them. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event input, one bit per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq_o | output | 1 | Maskable interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| err_n_o | output | 1 | Active-low external fault pin |

## Verification
The bench targets several corner cases, and each one exposes a specific design mistake:

- **Event and clear in the same cycle.** A design that lets the clear win would silently lose a fault.
- **Early key write.** The bench writes the key before the hold time has run out. A pin that releases early would show up as `err_n_o` rising too soon.
- **Key write with a fault still latched.** A design that skips the pending-status check would release the pin while a fault is still recorded.
- **Wrong key value.** This is aimed at a design that compares too few key bits.
- **Enable changes while status is set.** This catches an interrupt output that was registered or latched when it should follow the enables as a level.

// File: rtl/fault_aggregator.sv
module fault_aggregator #(
  parameter int NSRC = 16,
  parameter int HOLD_RST = 4,
  parameter logic [NSRC-1:0] KEY = 'hA5C3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_o,
  output logic            nmi_o,
  output logic            err_n_o
);

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_IEN  = 3'd1;
  localparam logic [2:0] A_NEN  = 3'd2;
  localparam logic [2:0] A_PEN  = 3'd3;
  localparam logic [2:0] A_HOLD = 3'd4;
  localparam logic [2:0] A_KEY  = 3'd5;
  localparam logic [NSRC-1:0] HOLD0 = NSRC'(HOLD_RST);

  logic [NSRC-1:0] status, ien, nen, pen, hold, cnt;
  logic            pin_act;

  wire [NSRC-1:0] clr     = (wr_en && addr == A_STAT) ? wdata : '0;
  wire            pin_set = |(evt_i & pen);
  wire            key_ok  = wr_en && addr == A_KEY && wdata == KEY &&
                            cnt == '0 && (status & pen) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      ien    <= '0;
      nen    <= '0;
      pen    <= '0;
      hold   <= HOLD0;
    end else begin
      status <= (status & ~clr) | evt_i;
      if (wr_en) begin
        case (addr)
          A_IEN:   ien  <= wdata;
          A_NEN:   nen  <= wdata;
          A_PEN:   pen  <= wdata;
          A_HOLD:  hold <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_act <= 1'b0;
      cnt     <= '0;
    end else if (pin_set) begin
      pin_act <= 1'b1;
      cnt     <= hold;
    end else begin
      if (key_ok) pin_act <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = status;
      A_IEN:   rdata = ien;
      A_NEN:   rdata = nen;
      A_PEN:   rdata = pen;
      A_HOLD:  rdata = hold;
      A_KEY:   rdata = {{(NSRC-1){1'b0}}, pin_act};
      default: rdata = '0;
    endcase
  end

  assign irq_o   = |(status & ien);
  assign nmi_o   = |(status & nen);
  assign err_n_o = ~pin_act;

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

  a_r7_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & pen) != '0) |=> !err_n_o);

  a_r8_hold_time: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_n_o && cnt != '0) |=> !err_n_o);

  a_r9_release_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n_o) |-> $past(wr_en && addr == A_KEY && wdata == KEY && (status & pen) == '0));

endmodule

// File: tb/fault_aggregator_test.sv
`timescale 1ns/100ps
module fault_aggregator_test;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o, nmi_o, err_n_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  fault_aggregator uut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o),
    .err_n_o(err_n_o));

  always #2.5 clk = ~clk;

  // reference model state
  logic [15:0] m_stat, m_ien, m_nen, m_pen, m_hold;
  int          m_cnt;
  bit          m_pin;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_ien;
      3'd2: return m_nen;
      3'd3: return m_pen;
      3'd4: return m_hold;
      3'd5: return {15'b0, m_pin};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_ien = 0; m_nen = 0; m_pen = 0; m_hold = 4; m_cnt = 0; m_pin = 0;
    end else begin
      bit keyw, pset;
      keyw = wr_en && addr == 3'd5 && wdata == KEY && m_cnt == 0 && (m_stat & m_pen) == 0;
      pset = (evt_i & m_pen) != 0;
      if (pset) begin m_pin = 1; m_cnt = int'(m_hold); end
      else begin
        if (keyw) m_pin = 0;
        if (m_cnt > 0) m_cnt--;
      end
      if (wr_en && addr == 3'd0) m_stat = m_stat & ~wdata;
      m_stat = m_stat | evt_i;
      if (wr_en) case (addr)
        3'd1: m_ien = wdata;
        3'd2: m_nen = wdata;
        3'd3: m_pen = wdata;
        3'd4: m_hold = wdata;
        default: ;
      endcase
      #1;
      chk("R5 irq", irq_o, (m_stat & m_ien) != 0);
      chk("R6 nmi", nmi_o, (m_stat & m_nen) != 0);
      chk("R7/R8 pin", err_n_o, !m_pin);
      chk(addr == 0 ? "R2 status read" : addr == 5 ? "R9 pin read" : "R11 readback",
          rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [15:0] exp);
    @(negedge clk); addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    // R1 reset state
    rd(3'd0, "R1 status", 16'h0);
    rd(3'd4, "R1 hold", 16'd4);
    rd(3'd1, "R1 irq enable", 16'h0);
    chk("R1 irq", irq_o, 0);
    chk("R1 nmi", nmi_o, 0);
    chk("R1 pin", err_n_o, 1);
    // R11 programming
    wr(3'd1, 16'h00FF); wr(3'd2, 16'h0F00); wr(3'd3, 16'h8001); wr(3'd4, 16'd6);
    rd(3'd1, "R11 ien", 16'h00FF);
    rd(3'd2, "R11 nen", 16'h0F00);
    rd(3'd3, "R11 pen", 16'h8001);
    rd(3'd4, "R11 hold", 16'd6);
    rd(3'd6, "R11 unused", 16'h0);
    // R2 / R5 / R7: source 3 raises irq only
    pulse(16'h0008); idle(3);
    rd(3'd0, "R2 sticky", 16'h0008);
    chk("R5 irq set", irq_o, 1);
    chk("R6 nmi quiet", nmi_o, 0);
    chk("R7 no pin", err_n_o, 1);
    // R6 source 9
    pulse(16'h0200);
    chk("R6 nmi set", nmi_o, 1);
    // R3 W1C on bit 3 only
    wr(3'd0, 16'h0008);
    rd(3'd0, "R3 clear one", 16'h0200);
    chk("R3 irq off", irq_o, 0);
    // R4 event and clear together
    @(negedge clk); evt_i = 16'h0200; wr_en = 1; addr = 3'd0; wdata = 16'h0200;
    @(negedge clk); evt_i = 0; wr_en = 0;
    rd(3'd0, "R4 set wins", 16'h0200);
    wr(3'd0, 16'h0200);
    // R5 level with enable change
    pulse(16'h0001);
    chk("R5 irq on", irq_o, 1);
    wr(3'd1, 16'h0000);
    chk("R5 irq follows enable", irq_o, 0);
    chk("R7 pin low", err_n_o, 0);
    // R9 status pending blocks key
    idle(10);
    wr(3'd5, KEY);
    chk("R9 pending blocks", err_n_o, 0);
    wr(3'd0, 16'hFFFF);
    // R10 wrong key
    wr(3'd5, 16'hA5C2);
    chk("R10 wrong key", err_n_o, 0);
    wr(3'd5, KEY);
    chk("R9 release", err_n_o, 1);
    rd(3'd5, "R9 pin read", 16'h0);
    // R8 early key ignored
    pulse(16'h8000);
    wr(3'd0, 16'h8000);
    wr(3'd5, KEY);
    chk("R8 too early", err_n_o, 0);
    idle(6);
    wr(3'd5, KEY);
    chk("R8 after hold", err_n_o, 1);
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule